// File: doc/BRIEF.md
# Halfband 2x Interpolation Filter

This block doubles the sample rate of a stream of 16-bit two's-complement samples with a fixed 47-tap halfband low-pass response. For each accepted input sample it delivers an output pair on one cycle of the same clock. The two samples leave on two parallel ports, and a downstream serializer or a faster clock domain sends them in order. The design is polyphase. The centre-tap branch reduces to a delay of the input, because its only coefficient is exactly 2^14. The other branch is a symmetric filter over 24 stored samples, built from 12 pre-added pairs and 12 constant multipliers.

Two instances in series give 4x interpolation. The second instance runs at twice the sample rate of the first and takes each pair from the first in order: even sample first, then odd. High-pass operation and spectral shifting belong to a separate mixer after the filter and are not part of this block.

Top module: `hb_interp2x`

## Requirements
- R1: With a history of accepted samples x0 (newest) to x23, the odd output equals the sum over j of c(j)*x(j), scaled per R3 and R4. c(0..11) = -5, 18, -42, 85, -158, 272, -444, 704, -1106, 1795, -3295, 10368, and c(23-j) = c(j). A single input of 16384 therefore reproduces c(j) on the odd output.
- R2: The even output of a pair equals x12, the sample accepted 12 samples before the newest. It is therefore the sample that precedes the odd output in time.
- R3: The odd sum is rounded half-up: add 8192, then shift arithmetically right by 14. A sum of 40.5 units gives 41 and a sum of -40.5 gives -40.
- R4: A scaled odd result above 32767 outputs 32767, and one below -32768 outputs -32768. It never wraps.
- R5: A constant input held for at least 24 samples gives that same value on both outputs (unity gain on each phase).
- R6: A sample accepted with in_valid high at clock edge k produces its pair, with out_valid high, after edge k+2.
- R7: out_valid stays low until 24 samples have been accepted since reset.
- R8: A cycle with in_valid low does not shift the history and produces no pair. Between pairs the outputs hold the last pair.
- R9: A synchronous reset clears the history, drives out_valid low and sets both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | in_data holds a sample to accept |
| in_data | input | 16 | Input sample, two's complement |
| out_valid | output | 1 | A new output pair is present |
| out_even | output | 16 | First sample of the pair (centre-tap phase) |
| out_odd | output | 16 | Second sample of the pair (filtered phase) |

## Verification
The checker enforces, on every cycle, the timing-level rules. A pair may appear only three sampled cycles after an accepted input, and never before 24 accepted samples. Outputs hold their value between pairs, and reset leaves them clear. The numerical behaviour can only be shown by the bench's scenarios against an independent reference: the coefficient values and their order, the exact half-up rounding point, saturation at both rails, the DC gain and the centre-phase alignment.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int HB_DATA_W = 16;
    localparam int HB_COEF_W = 16;
    localparam int HB_NPAIR  = 12;
    localparam int HB_SHIFT  = 14;

    // Outer half of the odd-phase coefficient set, outermost first.
    // The mirrored half uses hb_coef(2*NPAIR-1-k).
    function automatic logic signed [HB_COEF_W-1:0] hb_coef(input int k);
        case (k)
            0:       return -16'sd5;
            1:       return  16'sd18;
            2:       return -16'sd42;
            3:       return  16'sd85;
            4:       return -16'sd158;
            5:       return  16'sd272;
            6:       return -16'sd444;
            7:       return  16'sd704;
            8:       return -16'sd1106;
            9:       return  16'sd1795;
            10:      return -16'sd3295;
            11:      return  16'sd10368;
            default: return  16'sd0;
        endcase
    endfunction

endpackage

// File: rtl/hb_delay_line.sv
module hb_delay_line #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 24
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         shift_en,
    input  logic [DATA_W-1:0]            din,
    output logic [DEPTH-1:0][DATA_W-1:0] taps
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] taps;
    } dl_state_t;

    dl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.taps[0] = din;
            for (int i = 1; i < DEPTH; i++) begin
                st_d.taps[i] = st_q.taps[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign taps = st_q.taps;

endmodule

// File: rtl/hb_odd_mac.sv
module hb_odd_mac
    import hb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int NPAIR  = 12,
    parameter int NTAP   = 2 * NPAIR,
    parameter int PROD_W = DATA_W + 1 + COEF_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         win_valid,
    input  logic [NTAP-1:0][DATA_W-1:0]  taps,
    output logic                         prod_valid,
    output logic [DATA_W-1:0]            centre,
    output logic [NPAIR-1:0][PROD_W-1:0] prods
);

    localparam int PRE_W = DATA_W + 1;

    typedef struct packed {
        logic                         valid;
        logic [DATA_W-1:0]            centre;
        logic [NPAIR-1:0][PROD_W-1:0] prods;
    } mac_state_t;

    mac_state_t st_d, st_q;
    logic [NPAIR-1:0][PROD_W-1:0] prod_w;

    // One pre-adder and one constant multiplier per mirrored tap pair.
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam logic signed [COEF_W-1:0] CP = COEF_W'(hb_coef(p));
        logic signed [PRE_W-1:0]  pre;
        logic signed [PROD_W-1:0] prod;
        assign pre  = $signed({taps[p][DATA_W-1], taps[p]})
                    + $signed({taps[NTAP-1-p][DATA_W-1], taps[NTAP-1-p]});
        assign prod = pre * CP;
        assign prod_w[p] = prod;
    end

    always_comb begin
        st_d = st_q;
        st_d.valid = win_valid;
        if (win_valid) begin
            st_d.centre = taps[NPAIR];
            st_d.prods  = prod_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prod_valid = st_q.valid;
    assign centre     = st_q.centre;
    assign prods      = st_q.prods;

endmodule

// File: rtl/hb_sum_sat.sv
module hb_sum_sat #(
    parameter int DATA_W = 16,
    parameter int NPAIR  = 12,
    parameter int SHIFT  = 14,
    parameter int PROD_W = 33,
    parameter int ACC_W  = PROD_W + $clog2(NPAIR)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         prod_valid,
    input  logic [DATA_W-1:0]            centre,
    input  logic [NPAIR-1:0][PROD_W-1:0] prods,
    output logic                         out_valid,
    output logic [DATA_W-1:0]            out_even,
    output logic [DATA_W-1:0]            out_odd
);

    localparam logic signed [ACC_W-1:0] MAX_V  = ACC_W'((64'sd1 <<< (DATA_W-1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] MIN_V  = -MAX_V - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] HALF_V = ACC_W'(64'sd1 <<< (SHIFT-1));

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] even;
        logic [DATA_W-1:0] odd;
    } out_state_t;

    out_state_t st_d, st_q;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] rnd;
    logic signed [ACC_W-1:0] scaled;
    logic [DATA_W-1:0]       sat;

    always_comb begin
        acc = '0;
        for (int i = 0; i < NPAIR; i++) begin
            acc = acc + ACC_W'($signed(prods[i]));
        end
        rnd    = acc + HALF_V;
        scaled = rnd >>> SHIFT;
        if (scaled > MAX_V) begin
            sat = MAX_V[DATA_W-1:0];
        end else if (scaled < MIN_V) begin
            sat = MIN_V[DATA_W-1:0];
        end else begin
            sat = scaled[DATA_W-1:0];
        end
    end

    always_comb begin
        st_d = st_q;
        st_d.valid = prod_valid;
        if (prod_valid) begin
            st_d.even = centre;
            st_d.odd  = sat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_even  = st_q.even;
    assign out_odd   = st_q.odd;

endmodule

// File: rtl/hb_interp2x.sv
module hb_interp2x
    import hb_pkg::*;
#(
    parameter int DATA_W = HB_DATA_W,
    parameter int COEF_W = HB_COEF_W,
    parameter int NPAIR  = HB_NPAIR,
    parameter int SHIFT  = HB_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_even,
    output logic [DATA_W-1:0] out_odd
);

    localparam int NTAP   = 2 * NPAIR;
    localparam int CNT_W  = $clog2(NTAP + 1);
    localparam int PROD_W = DATA_W + 1 + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(NPAIR);

    typedef struct packed {
        logic [CNT_W-1:0] fill;
        logic             win;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;

    logic [NTAP-1:0][DATA_W-1:0]  taps;
    logic                         prod_valid;
    logic [DATA_W-1:0]            centre;
    logic [NPAIR-1:0][PROD_W-1:0] prods;

    // The window is complete once NTAP samples have been accepted.
    always_comb begin
        ctl_d = ctl_q;
        ctl_d.win = in_valid && (ctl_q.fill >= CNT_W'(NTAP - 1));
        if (in_valid && (ctl_q.fill < CNT_W'(NTAP))) begin
            ctl_d.fill = ctl_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    hb_delay_line #(
        .DATA_W (DATA_W),
        .DEPTH  (NTAP)
    ) i_delay (
        .clk      (clk),
        .rst      (rst),
        .shift_en (in_valid),
        .din      (in_data),
        .taps     (taps)
    );

    hb_odd_mac #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .NPAIR  (NPAIR),
        .NTAP   (NTAP),
        .PROD_W (PROD_W)
    ) i_mac (
        .clk        (clk),
        .rst        (rst),
        .win_valid  (ctl_q.win),
        .taps       (taps),
        .prod_valid (prod_valid),
        .centre     (centre),
        .prods      (prods)
    );

    hb_sum_sat #(
        .DATA_W (DATA_W),
        .NPAIR  (NPAIR),
        .SHIFT  (SHIFT),
        .PROD_W (PROD_W),
        .ACC_W  (ACC_W)
    ) i_sum (
        .clk        (clk),
        .rst        (rst),
        .prod_valid (prod_valid),
        .centre     (centre),
        .prods      (prods),
        .out_valid  (out_valid),
        .out_even   (out_even),
        .out_odd    (out_odd)
    );

endmodule

// File: rtl/hb_interp2x_chk.sv
module hb_interp2x_chk #(
    parameter int DATA_W = 16,
    parameter int NTAP   = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_even,
    input logic [DATA_W-1:0] out_odd
);

    localparam int CW = $clog2(NTAP + 1);

    logic [CW-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (in_valid && (seen_q < CW'(NTAP))) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    // R9
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && (out_even == '0) && (out_odd == '0)));

    // R6
    pair_origin_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3));

    // R7
    fill_wait_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (seen_q >= CW'(NTAP)));

    // R8
    hold_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> ($stable(out_even) && $stable(out_odd)));

endmodule

bind hb_interp2x hb_interp2x_chk #(
    .DATA_W (DATA_W),
    .NTAP   (2 * NPAIR)
) i_hb_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_even  (out_even),
    .out_odd   (out_odd)
);

// File: tb/test_hb_interp2x.sv
`timescale 1ns/1ps
module test_hb_interp2x;

    localparam int DW = 16;
    localparam int NP = 12;
    localparam int NT = 24;

    typedef struct packed {
        logic signed [15:0] stim;
        logic signed [15:0] ee;
        logic signed [15:0] eo;
    } vec_t;

    // Impulse of 16384 walked through the window: odd output reproduces c(j) (R1),
    // even output is the impulse when it sits at position 12 (R2).
    localparam vec_t VEC [NT] = '{
        '{16'sd16384, 16'sd0,     -16'sd5},
        '{16'sd0,     16'sd0,      16'sd18},
        '{16'sd0,     16'sd0,     -16'sd42},
        '{16'sd0,     16'sd0,      16'sd85},
        '{16'sd0,     16'sd0,     -16'sd158},
        '{16'sd0,     16'sd0,      16'sd272},
        '{16'sd0,     16'sd0,     -16'sd444},
        '{16'sd0,     16'sd0,      16'sd704},
        '{16'sd0,     16'sd0,     -16'sd1106},
        '{16'sd0,     16'sd0,      16'sd1795},
        '{16'sd0,     16'sd0,     -16'sd3295},
        '{16'sd0,     16'sd0,      16'sd10368},
        '{16'sd0,     16'sd16384,  16'sd10368},
        '{16'sd0,     16'sd0,     -16'sd3295},
        '{16'sd0,     16'sd0,      16'sd1795},
        '{16'sd0,     16'sd0,     -16'sd1106},
        '{16'sd0,     16'sd0,      16'sd704},
        '{16'sd0,     16'sd0,     -16'sd444},
        '{16'sd0,     16'sd0,      16'sd272},
        '{16'sd0,     16'sd0,     -16'sd158},
        '{16'sd0,     16'sd0,      16'sd85},
        '{16'sd0,     16'sd0,     -16'sd42},
        '{16'sd0,     16'sd0,      16'sd18},
        '{16'sd0,     16'sd0,     -16'sd5}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_even;
    logic [DW-1:0] out_odd;

    always #2.5 clk = ~clk;

    hb_interp2x i_hb_interp2x (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_even  (out_even),
        .out_odd   (out_odd)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int    hist [NT];
    int    acc_cnt = 0;
    bit    pv [3];
    int    pe [3];
    int    po [3];
    bit    pt [3];
    int    pte [3];
    int    pto [3];
    string ptag [3];
    int    mo_e = 0;
    int    mo_o = 0;
    string tag = "R9";
    bit    tbl_on = 0;
    int    tbl_e = 0;
    int    tbl_o = 0;
    int    seed = 32'h1234_5678;

    function automatic int coef(int j);
        int k;
        k = (j < NP) ? j : (NT - 1 - j);
        case (k)
            0: return -5;      1: return 18;     2: return -42;
            3: return 85;      4: return -158;   5: return 272;
            6: return -444;    7: return 704;    8: return -1106;
            9: return 1795;    10: return -3295; 11: return 10368;
            default: return 0;
        endcase
    endfunction

    function automatic int ref_odd();
        longint a;
        a = 0;
        for (int j = 0; j < NT; j++) a += longint'(coef(j)) * longint'(hist[j]);
        a = (a + 64'sd8192) >>> 14;
        if (a > 32767) a = 32767;
        if (a < -32768) a = -32768;
        return int'(a);
    endfunction

    task automatic check(string t, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
        end
    endtask

    task automatic tick(bit r, bit v, int d);
        @(negedge clk);
        if (pv[2]) begin
            mo_e = pe[2];
            mo_o = po[2];
        end
        check(ptag[2], "out_valid", int'(out_valid), int'(pv[2]));
        check(ptag[2], "out_even", int'($signed(out_even)), mo_e);
        check(ptag[2], "out_odd", int'($signed(out_odd)), mo_o);
        if (pt[2]) begin
            check((ptag[2] == "R1") ? "R2" : ptag[2], "table even", int'($signed(out_even)), pte[2]);
            check(ptag[2], "table odd", int'($signed(out_odd)), pto[2]);
        end
        for (int s = 2; s > 0; s--) begin
            pv[s] = pv[s-1]; pe[s] = pe[s-1]; po[s] = po[s-1];
            pt[s] = pt[s-1]; pte[s] = pte[s-1]; pto[s] = pto[s-1]; ptag[s] = ptag[s-1];
        end
        rst = r;
        in_valid = v;
        in_data = d[DW-1:0];
        pv[0] = 0; pt[0] = 0; ptag[0] = tag; pte[0] = tbl_e; pto[0] = tbl_o;
        if (r) begin
            for (int j = 0; j < NT; j++) hist[j] = 0;
            acc_cnt = 0;
            for (int s = 0; s < 3; s++) begin pv[s] = 0; pt[s] = 0; end
            mo_e = 0;
            mo_o = 0;
        end else if (v) begin
            for (int j = NT - 1; j > 0; j--) hist[j] = hist[j-1];
            hist[0] = int'($signed(d[DW-1:0]));
            if (acc_cnt < NT) acc_cnt++;
            pv[0] = (acc_cnt >= NT);
            pe[0] = hist[NP];
            po[0] = ref_odd();
            pt[0] = tbl_on;
        end
        tbl_on = 0;
    endtask

    task automatic feed_zeros(int n);
        for (int i = 0; i < n; i++) tick(0, 1, 0);
    endtask

    function automatic int next_rand();
        logic [15:0] r16;
        seed = seed * 1103515245 + 12345;
        r16 = seed[23:8];
        return int'($signed(r16));
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < NT; j++) hist[j] = 0;
        for (int s = 0; s < 3; s++) begin pv[s] = 0; pt[s] = 0; ptag[s] = "R9"; end

        // R9: reset state
        tag = "R9";
        for (int i = 0; i < 3; i++) tick(1, 0, 0);

        // R7: no pair before 24 accepted samples
        tag = "R7";
        for (int i = 0; i < 30; i++) tick(0, 1, 100 * i - 1000);

        // R5: DC gain on both phases
        tag = "R5";
        for (int i = 0; i < 30; i++) tick(0, 1, 1234);
        check("R5", "dc odd", int'($signed(out_odd)), 1234);
        check("R5", "dc even", int'($signed(out_even)), 1234);

        // R1 / R2: impulse response table
        tag = "R1";
        feed_zeros(NT);
        for (int k = 0; k < NT; k++) begin
            tbl_on = 1;
            tbl_e = int'(VEC[k].ee);
            tbl_o = int'(VEC[k].eo);
            tick(0, 1, int'(VEC[k].stim));
        end

        // R3: exact half-unit points round upward
        tag = "R3";
        feed_zeros(NT);
        tick(0, 1, 64);
        feed_zeros(10);
        tbl_on = 1; tbl_e = 0; tbl_o = 41;
        tick(0, 1, 0);
        feed_zeros(NT);
        tick(0, 1, -64);
        feed_zeros(10);
        tbl_on = 1; tbl_e = 0; tbl_o = -40;
        tick(0, 1, 0);
        for (int i = 0; i < 60; i++) tick(0, 1, next_rand());

        // R4: saturation at both rails
        tag = "R4";
        for (int j = NT - 1; j >= 0; j--) begin
            if (j == 0) begin tbl_on = 1; tbl_e = 32767; tbl_o = 32767; end
            tick(0, 1, (coef(j) > 0) ? 32767 : -32768);
        end
        for (int j = NT - 1; j >= 0; j--) begin
            if (j == 0) begin tbl_on = 1; tbl_e = -32768; tbl_o = -32768; end
            tick(0, 1, (coef(j) > 0) ? -32768 : 32767);
        end

        // R8: gaps in in_valid hold the history and the outputs
        tag = "R8";
        for (int i = 0; i < 40; i++) tick(0, (i % 3) != 1, next_rand());

        // R6: isolated samples appear two edges after acceptance
        tag = "R6";
        for (int i = 0; i < 4; i++) begin
            for (int g = 0; g < 4; g++) tick(0, 0, 7);
            tick(0, 1, next_rand());
        end
        for (int g = 0; g < 4; g++) tick(0, 0, 0);

        // R9: reset in mid-stream, then refill
        tag = "R9";
        tick(1, 1, 555);
        tick(1, 0, 0);
        tag = "R7";
        for (int i = 0; i < 28; i++) tick(0, 1, next_rand());
        for (int i = 0; i < 4; i++) tick(0, 0, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule